// File: doc/BRIEF.md
# Serial Shift-Register Port Expander Sequencer

This block widens a controller's parallel I/O by driving chains of external shift registers through an SPI master byte engine and one active-low strobe line. A user command starts one of three operations: a two-byte output write, a two-byte input read, or a single-byte write to one of four addressed output ports. The sequencer issues byte transfers to the SPI engine through a start/done handshake. It then frames each operation with a strobe pulse that goes low and then returns high.

For an output write, the byte meant for the farther register is shifted first, and the strobe pulse comes after both bytes. The external registers update their parallel pins on the rising edge of that pulse. For an input read, the strobe pulse comes first, so the external registers capture their inputs on its rising edge. Two dummy bytes are then exchanged. In addressed-port mode, the port address is set while the strobe is high, which keeps the decoder off. One byte is shifted, and the strobe pulse is steered through a decoder to the addressed port only. Each strobe phase lasts a programmable number of clock cycles.

Top module: `spi_expander_seq`

## Requirements
- R1: After reset, strobeN is 1, busy is 0, cmdReady is 1, spiStart is 0 and every bit of portLatchN is 1.
- R2: A write-pair command (cmdOp 2'b00) sends cmdData[15:8] as the first byte and cmdData[7:0] as the second. After latching, the far register holds the upper byte and the near register holds the lower byte.
- R3: In a write-pair operation, the strobe goes low only after the second byte's spiDone. It stays low for exactly the latched phase length and then rises.
- R4: A read-pair command (cmdOp 2'b01) first drives the strobe low for the phase length. It then holds the strobe high for the phase length before the first spiStart. Both bytes sent during a read are 8'hFF.
- R5: In a read-pair operation, the first received byte goes to rdData[7:0] and the second to rdData[15:8]. rdValid pulses for one cycle, and busy is already low in that cycle.
- R6: An addressed-port command (cmdOp[1] = 1) presents cmdAddr on portAddr and holds the strobe high for the phase length before sending cmdData[7:0]. It then pulses the strobe low for the phase length. During that pulse only portLatchN[cmdAddr] goes low.
- R7: Every bit of portLatchN is 1 whenever strobeN is 1, and also throughout write-pair and read-pair operations.
- R8: cmdReady equals !busy. A command is accepted only when cmdValid is 1 while the sequencer is idle. A command presented while busy is ignored.
- R9: busy stays high from acceptance until the strobe's final rising edge for write-pair and port operations; it falls in the same cycle that strobeN rises. spiStart is never asserted while strobeN is low.
- R10: The phase length is cmdPhase, sampled at acceptance. A value of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Command can be accepted |
| cmdOp | input | 2 | 00 write pair, 01 read pair, 1x addressed port |
| cmdData | input | 16 | Write data; upper byte for the far register |
| cmdAddr | input | 2 | Target port for addressed-port mode |
| cmdPhase | input | 8 | Strobe phase length in clock cycles |
| busy | output | 1 | Operation in progress |
| rdData | output | 16 | Read result; lower byte from the near register |
| rdValid | output | 1 | One-cycle pulse when rdData is complete |
| spiStart | output | 1 | One-cycle request for a byte transfer |
| spiTxByte | output | 8 | Byte to transmit |
| spiDone | input | 1 | Byte transfer finished |
| spiRxByte | input | 8 | Byte received, valid with spiDone |
| strobeN | output | 1 | Active-low latch/load strobe, idles high |
| portAddr | output | 2 | Address presented to the port decoder |
| portLatchN | output | 4 | Decoded active-low latch strobes per port |

## Verification
The hardest case to reach is a command that arrives while an operation is in flight and must leave no trace. To produce it, the bench holds cmdValid high with different data through the middle of a write. It then confirms that the latched output carries only the first command's value and that busy stays low afterwards. Phase timing is also hard to observe, especially the high interval between the load edge and the first byte of a read. The bench measures it against the requested length, including the zero-means-one case. Models of the external output chain, input chain and port registers turn every strobe edge into a scoreboard comparison.

// File: rtl/spx_pkg.sv
package spx_pkg;
  typedef logic [1:0] op_t;
  localparam op_t OP_WRITE = 2'b00;
  localparam op_t OP_READ  = 2'b01;

  typedef struct packed {
    logic loadCmd;
    logic txSecond;
    logic capLo;
    logic capHi;
    logic cntRun;
    logic cntClr;
  } ctl_t;
endpackage

// File: rtl/spx_datapath.sv
module spx_datapath #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int NPORT  = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  spx_pkg::ctl_t        ctl,
  input  spx_pkg::op_t         cmdOp,
  input  logic [WORD_W-1:0]    cmdData,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [CNT_W-1:0]     cmdPhase,
  input  logic                 strobeN,
  input  logic [BYTE_W-1:0]    spiRxByte,
  output spx_pkg::op_t         opQ,
  output logic                 phaseEnd,
  output logic [BYTE_W-1:0]    spiTxByte,
  output logic [WORD_W-1:0]    rdData,
  output logic                 rdValid,
  output logic [ADDR_W-1:0]    portAddr,
  output logic [NPORT-1:0]     portLatchN
);
  import spx_pkg::*;

  logic [WORD_W-1:0] dataQ;
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  limQ;
  logic [CNT_W-1:0]  phaseCnt;
  logic              portMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_WRITE;
      dataQ <= '0;
      addrQ <= '0;
      limQ  <= CNT_W'(1);
    end else if (ctl.loadCmd) begin
      opQ   <= cmdOp;
      dataQ <= cmdData;
      addrQ <= cmdAddr;
      limQ  <= (cmdPhase == '0) ? CNT_W'(1) : cmdPhase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phaseCnt <= '0;
    else if (ctl.cntClr)  phaseCnt <= '0;
    else if (ctl.cntRun)  phaseCnt <= phaseCnt + CNT_W'(1);
  end

  assign phaseEnd = (phaseCnt >= limQ - CNT_W'(1));

  always_comb begin
    if (opQ == OP_READ)   spiTxByte = '1;
    else if (opQ[1])      spiTxByte = dataQ[BYTE_W-1:0];
    else if (ctl.txSecond) spiTxByte = dataQ[BYTE_W-1:0];
    else                  spiTxByte = dataQ[WORD_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.capHi;
      if (ctl.capLo) rdData[BYTE_W-1:0]      <= spiRxByte;
      if (ctl.capHi) rdData[WORD_W-1:BYTE_W] <= spiRxByte;
    end
  end

  assign portAddr = addrQ;
  assign portMode = opQ[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    assign portLatchN[p] = !(portMode && !strobeN && (addrQ == ADDR_W'(p)));
  end

  p_decoder_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobeN |-> (&portLatchN));
  p_one_port_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~portLatchN) <= 1);
  p_rdvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);
  p_phase_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntRun |-> (phaseCnt < limQ));
endmodule

// File: rtl/spx_control.sv
module spx_control (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdValid,
  input  spx_pkg::op_t   cmdOp,
  input  spx_pkg::op_t   opQ,
  input  logic           spiDone,
  input  logic           phaseEnd,
  output spx_pkg::ctl_t  ctl,
  output logic           busy,
  output logic           cmdReady,
  output logic           strobeN,
  output logic           spiStart
);
  import spx_pkg::*;

  typedef enum logic [2:0] {
    S_IDLE, S_TX1, S_W1, S_TX2, S_W2, S_LOW, S_HIGH
  } state_e;

  state_e state, nextState;
  logic   accept;

  assign busy     = (state != S_IDLE);
  assign cmdReady = !busy;
  assign accept   = cmdValid && !busy;
  assign strobeN  = (state != S_LOW);
  assign spiStart = (state == S_TX1) || (state == S_TX2);

  always_comb begin
    nextState    = state;
    ctl          = '0;
    ctl.loadCmd  = accept;
    ctl.txSecond = (state == S_TX2) || (state == S_W2);
    unique case (state)
      S_IDLE: if (accept) begin
        if (cmdOp[1])              nextState = S_HIGH;
        else if (cmdOp == OP_READ) nextState = S_LOW;
        else                       nextState = S_TX1;
      end
      S_TX1: nextState = S_W1;
      S_W1: if (spiDone) begin
        ctl.capLo = (opQ == OP_READ);
        nextState = opQ[1] ? S_LOW : S_TX2;
      end
      S_TX2: nextState = S_W2;
      S_W2: if (spiDone) begin
        ctl.capHi = (opQ == OP_READ);
        nextState = (opQ == OP_READ) ? S_IDLE : S_LOW;
      end
      S_LOW: begin
        ctl.cntRun = !phaseEnd;
        ctl.cntClr = phaseEnd;
        if (phaseEnd) nextState = (opQ == OP_READ) ? S_HIGH : S_IDLE;
      end
      S_HIGH: begin
        ctl.cntRun = !phaseEnd;
        ctl.cntClr = phaseEnd;
        if (phaseEnd) nextState = S_TX1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  p_no_start_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    spiStart |-> strobeN);
  p_low_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |-> busy);
  p_busy_fall_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> strobeN);
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> $stable(opQ));
endmodule

// File: rtl/spi_expander_seq.sv
module spi_expander_seq #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int NPORT  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [WORD_W-1:0] cmdData,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdPhase,
  output logic              busy,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              spiStart,
  output logic [BYTE_W-1:0] spiTxByte,
  input  logic              spiDone,
  input  logic [BYTE_W-1:0] spiRxByte,
  output logic              strobeN,
  output logic [ADDR_W-1:0] portAddr,
  output logic [NPORT-1:0]  portLatchN
);
  spx_pkg::ctl_t ctl;
  spx_pkg::op_t  opQ;
  logic          phaseEnd;

  spx_control u_control (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .opQ(opQ),
    .spiDone(spiDone), .phaseEnd(phaseEnd), .ctl(ctl), .busy(busy),
    .cmdReady(cmdReady), .strobeN(strobeN), .spiStart(spiStart)
  );

  spx_datapath #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdOp(cmdOp), .cmdData(cmdData),
    .cmdAddr(cmdAddr), .cmdPhase(cmdPhase), .strobeN(strobeN),
    .spiRxByte(spiRxByte), .opQ(opQ), .phaseEnd(phaseEnd),
    .spiTxByte(spiTxByte), .rdData(rdData), .rdValid(rdValid),
    .portAddr(portAddr), .portLatchN(portLatchN)
  );
endmodule

// File: tb/spi_expander_seq_bench.sv
`timescale 1ns/1ps
module spi_expander_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic cmdValid = 0, cmdReady, busy, rdValid, spiStart, spiDone = 0, strobeN;
  logic [1:0] cmdOp = 0, cmdAddr = 0, portAddr;
  logic [15:0] cmdData = 0, rdData;
  logic [7:0] cmdPhase = 1, spiTxByte, spiRxByte = 0;
  logic [3:0] portLatchN;

  spi_expander_seq u_spi_expander_seq (.*);

  int errors = 0, checks = 0;
  typedef struct {int kind; int addr; logic [15:0] data;} item_t;
  item_t sbq[$];

  logic [1:0] curOp = 0;
  int curPhase = 1;
  logic [7:0] outNear = 0, outFar = 0, inNear = 0, inFar = 0, parNear = 0, parFar = 0;
  logic [7:0] lastByte = 0, txHold = 0;
  logic [7:0] portOut [4];
  logic [7:0] expPort [4];
  int pend = 0, lowCnt = 0, hiCnt = 0;
  bit hiArm = 0, portArm = 0, portSeen = 0;
  logic prevStrobe = 1, prevBusy = 0;
  logic [3:0] prevLatch = '1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbEvent(input int kind, input int addr, input logic [15:0] data, input string req);
    item_t e;
    if (sbq.size() == 0) begin chk(0, req, data, 0); return; end
    e = sbq.pop_front();
    chk(e.kind == kind && e.addr == addr && e.data == data, req, data, e.data);
  endtask

  function automatic int effPhase();
    return (curPhase == 0) ? 1 : curPhase;
  endfunction

  // SPI engine, external register models and monitor
  always @(negedge clk) begin
    spiDone = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        spiDone = 1;
        spiRxByte = inNear;
        inNear = inFar; inFar = 8'h00;
        outFar = outNear; outNear = txHold;
        lastByte = txHold;
      end
    end
    if (spiStart) begin
      pend = 3; txHold = spiTxByte;
      chk(strobeN == 1, "R9 start while strobe low", strobeN, 1);
      if (curOp == 2'b01) chk(spiTxByte == 8'hFF, "R4 dummy byte", spiTxByte, 8'hFF);
      if (hiArm) begin chk(hiCnt == effPhase(), "R4 high before first byte", hiCnt, effPhase()); hiArm = 0; end
      if (portArm) begin chk(hiCnt == effPhase(), "R6 address setup high", hiCnt, effPhase()); portArm = 0; end
    end else if (hiArm || portArm) hiCnt++;
    if (curOp[1] && busy && !prevBusy) begin portArm = 1; hiCnt = 1; end
    if (curOp[1] && busy) chk(portAddr == cmdAddr, "R6 portAddr", portAddr, cmdAddr);
    if (!strobeN) lowCnt++;
    if (strobeN && !prevStrobe) begin
      if (curOp == 2'b01) begin
        chk(lowCnt == effPhase(), "R4 load pulse width", lowCnt, effPhase());
        chk(busy == 1, "R4 busy after load", busy, 1);
        inNear = parNear; inFar = parFar; hiArm = 1; hiCnt = 1;
      end else begin
        chk(lowCnt == effPhase(), "R3 latch pulse width", lowCnt, effPhase());
        chk(busy == 0, "R9 busy falls with strobe rise", busy, 0);
        if (curOp == 2'b00) sbEvent(0, 0, {outFar, outNear}, "R2 latched word");
      end
      lowCnt = 0;
    end
    if (strobeN || !curOp[1]) chk(portLatchN == 4'hF, "R7 decoder off", portLatchN, 4'hF);
    for (int i = 0; i < 4; i++)
      if (portLatchN[i] && !prevLatch[i]) begin
        portOut[i] = lastByte;
        sbEvent(2, i, {8'h00, lastByte}, "R6 port latch");
      end
    if (rdValid) begin
      chk(busy == 0, "R5 busy low at rdValid", busy, 0);
      sbEvent(1, 0, rdData, "R5 read word");
    end
    chk(cmdReady == !busy, "R8 cmdReady", cmdReady, !busy);
    prevStrobe = strobeN; prevBusy = busy; prevLatch = portLatchN;
  end

  task automatic issue(input logic [1:0] op, input logic [15:0] d, input logic [1:0] a, input int ph);
    item_t e;
    @(negedge clk);
    curOp = op; curPhase = ph;
    if (op == 2'b00) e = '{0, 0, d};
    else if (op == 2'b01) e = '{1, 0, {parFar, parNear}};
    else begin e = '{2, a, {8'h00, d[7:0]}}; expPort[a] = d[7:0]; end
    sbq.push_back(e);
    cmdOp = op; cmdData = d; cmdAddr = a; cmdPhase = ph[7:0]; cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", wd);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin portOut[i] = 0; expPort[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(strobeN == 1, "R1 strobeN", strobeN, 1);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(cmdReady == 1, "R1 cmdReady", cmdReady, 1);
    chk(spiStart == 0, "R1 spiStart", spiStart, 0);
    chk(portLatchN == 4'hF, "R1 portLatchN", portLatchN, 4'hF);
    rstN = 1;
    repeat (2) @(negedge clk);
    // R2 R3 writes, various phases (R10 zero phase)
    issue(2'b00, 16'hABCD, 0, 2);
    issue(2'b00, 16'h1234, 0, 0);
    issue(2'b00, 16'hF00F, 0, 5);
    // R4 R5 reads
    parNear = 8'h5A; parFar = 8'hC3;
    issue(2'b01, 16'h0000, 0, 1);
    parNear = 8'h01; parFar = 8'hFE;
    issue(2'b01, 16'hFFFF, 0, 4);
    parNear = 8'h77; parFar = 8'h88;
    issue(2'b01, 16'h0000, 0, 0);
    // R6 R7 addressed ports
    issue(2'b10, 16'h0011, 2'd0, 1);
    issue(2'b11, 16'h0022, 2'd3, 3);
    issue(2'b10, 16'h0033, 2'd1, 0);
    issue(2'b10, 16'h0044, 2'd2, 2);
    issue(2'b10, 16'h0055, 2'd3, 1);
    for (int i = 0; i < 4; i++)
      chk(portOut[i] == expPort[i], "R6 port contents", portOut[i], expPort[i]);
    // R8 command presented while busy is ignored
    @(negedge clk);
    curOp = 2'b00; curPhase = 3;
    sbq.push_back('{0, 0, 16'h6699});
    cmdOp = 2'b00; cmdData = 16'h6699; cmdPhase = 3; cmdValid = 1;
    @(negedge clk);
    cmdData = 16'h1111; cmdOp = 2'b01; cmdPhase = 9;
    repeat (6) begin
      chk(cmdReady == 0, "R8 not ready while busy", cmdReady, 0);
      @(negedge clk);
    end
    cmdValid = 0;
    while (busy) @(negedge clk);
    repeat (10) begin
      @(negedge clk);
      chk(busy == 0, "R8 no second operation", busy, 0);
    end
    chk(sbq.size() == 0, "R8 scoreboard drained", sbq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule